// File: doc/BRIEF.md
# Code-Selected Reference Divider

This block divides a reference oscillator clock by one of eight fixed ratios and emits a one-clock pulse once per divided period. The pulse is meant for the reference side of a phase comparator. A 3-bit code input picks the ratio. The available ratios are 8, 64, 128, 256, 640, 1000, 1024 and 2048, so two of them are not powers of two. A small lookup table turns the code into a terminal count. A 12-bit down counter then counts that value off.

A three-state controller runs the division:

- `ST_RST` is held by the synchronous reset.
- `ST_RUN` counts down.
- `ST_TERM` is the single terminal cycle, in which the pulse is high.

The transitions are:

- T_RESET: any state goes to `ST_RST` while reset is high.
- T_START: `ST_RST` goes to `ST_RUN`. The counter loads ratio minus one.
- T_COUNT: `ST_RUN` stays in `ST_RUN`. The counter decrements.
- T_EXPIRE: `ST_RUN` goes to `ST_TERM` when the count reaches one. The counter steps to zero.
- T_RELOAD: `ST_TERM` goes to `ST_RUN`. The counter reloads from the code present at that edge.

The code is only read on the loading edges (T_START and T_RELOAD). A change partway through a count therefore shows up only in the next period.

Top module: `ref_code_divider`

## Requirements
- R1: The code selects the ratio in ascending order: 000→8, 001→64, 010→128, 011→256, 100→640, 101→1000, 110→1024, 111→2048.
- R2: While the code is held, `ref_tick` is high once every D clock cycles, where D is the selected ratio.
- R3: `ref_tick` is never high for two consecutive cycles. This also holds for the smallest ratio when periods run back to back.
- R4: Take the first rising edge with reset low as edge 1. The first `ref_tick` is high in the cycle that follows edge D.
- R5: A code change during a count leaves the current period unchanged. The new ratio applies from the next reload edge.
- R6: While `srst` is high at a rising edge, `ref_tick` is low after that edge and the count is cleared. After reset is released, counting starts a fresh period, and any partial count before the reset has no effect.
- R7: While counting, the 12-bit count never exceeds the terminal value loaded for the current period. It never decrements past zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Reference oscillator clock; all state changes on its rising edge |
| srst | input | 1 | Synchronous reset, active high |
| ratio_code | input | 3 | Ratio select code, sampled only on loading edges |
| ref_tick | output | 1 | One-cycle divided reference pulse |

## Verification
The hardest case to reach from the ports is a code change that lands strictly inside a running period. The design has to keep the old terminal count until the reload and then pick up the new one. Any slip shows up only as a shifted pulse one or two thousand cycles later.

The stimulus places the scoreboard's expected pulse cycles from the old ratio. It then switches the code a fixed number of cycles after a reload: from 8 to 2048 three cycles in, and from 1000 to 64 five hundred cycles in. This checks both the period that must stay untouched and the one that must adopt the new code. A reset asserted in the middle of a 640 count covers the other path that leaves a partial count behind.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int CODE_W    = 3;
    localparam int CNT_W     = 12;
    localparam int NUM_CODES = 1 << CODE_W;

    typedef enum logic [1:0] {
        ST_RST  = 2'd0,
        ST_RUN  = 2'd1,
        ST_TERM = 2'd2
    } div_state_t;

    // Division ratio for each select code, ascending with the code value.
    function automatic int ratio_of(input int code);
        case (code)
            0:       return 8;
            1:       return 64;
            2:       return 128;
            3:       return 256;
            4:       return 640;
            5:       return 1000;
            6:       return 1024;
            default: return 2048;
        endcase
    endfunction

endpackage

// File: rtl/refdiv_ratio_rom.sv
module refdiv_ratio_rom
    import refdiv_pkg::*;
#(
    parameter int SEL_W = CODE_W,
    parameter int CW    = CNT_W
) (
    input  logic [SEL_W-1:0] code,
    output logic [CW-1:0]    term
);
    localparam int ENTRIES = 1 << SEL_W;

    logic [CW-1:0] table_q [ENTRIES];

    // Each entry is the terminal value (ratio minus one) that the counter loads.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        assign table_q[i] = CW'(ratio_of(i) - 1);
    end

    assign term = table_q[code];

endmodule

// File: rtl/refdiv_downcnt.sv
module refdiv_downcnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         at_one
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - W'(1);
        end
    end

    assign at_one = (cnt == W'(1));

    // R2: each counting cycle removes exactly one from the count
    assert_dec_step_R2: assert property (@(posedge clk) disable iff (rst)
        (dec && !load) |=> (cnt == $past(cnt) - W'(1)));

    // R7: no decrement is ever requested at zero
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        dec |-> (cnt != '0));

endmodule

// File: rtl/refdiv_ctrl.sv
module refdiv_ctrl
    import refdiv_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] rom_term,
    input  logic [CW-1:0] cnt,
    input  logic          at_one,
    output logic          cnt_load,
    output logic          cnt_dec,
    output logic          tick
);
    div_state_t    state_q, state_d;
    logic [CW-1:0] cur_term_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RST;
        end else begin
            state_q <= state_d;
        end
    end

    // Terminal value adopted for the running period (captured on loads only)
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_term_q <= '0;
        end else if (cnt_load) begin
            cur_term_q <= rom_term;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RST:  state_d = ST_RUN;                        // T_START
            ST_RUN:  state_d = at_one ? ST_TERM : ST_RUN;     // T_EXPIRE / T_COUNT
            ST_TERM: state_d = ST_RUN;                        // T_RELOAD
            default: state_d = ST_RST;
        endcase
    end

    // Output decode
    always_comb begin
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        tick     = 1'b0;
        unique case (state_q)
            ST_RST:  cnt_load = 1'b1;
            ST_RUN:  cnt_dec  = 1'b1;
            ST_TERM: begin
                cnt_load = 1'b1;
                tick     = 1'b1;
            end
            default: ;
        endcase
    end

    // R3: the terminal state lasts exactly one cycle
    assert_term_single_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TERM) |=> (state_q == ST_RUN));

    // R2: reaching a count of one while running leads to the terminal cycle
    assert_expire_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && at_one) |=> (state_q == ST_TERM && cnt == '0));

    // R4: leaving reset loads the terminal value decoded at that edge
    assert_first_load_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RST) |=> (state_q == ST_RUN && cnt == $past(rom_term)));

    // R5: the adopted terminal value is frozen while a period runs
    assert_hold_term_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |=> (cur_term_q == $past(cur_term_q)));

    // R7: the running count stays within the adopted terminal value
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> (cnt <= cur_term_q));

endmodule

// File: rtl/ref_code_divider.sv
module ref_code_divider
    import refdiv_pkg::*;
(
    input  logic              osc_clk,
    input  logic              srst,
    input  logic [CODE_W-1:0] ratio_code,
    output logic              ref_tick
);
    logic [CNT_W-1:0] term;
    logic [CNT_W-1:0] cnt;
    logic             at_one;
    logic             cnt_load;
    logic             cnt_dec;

    refdiv_ratio_rom #(
        .SEL_W (CODE_W),
        .CW    (CNT_W)
    ) u_rom (
        .code (ratio_code),
        .term (term)
    );

    refdiv_downcnt #(
        .W (CNT_W)
    ) u_cnt (
        .clk      (osc_clk),
        .rst      (srst),
        .load     (cnt_load),
        .dec      (cnt_dec),
        .load_val (term),
        .cnt      (cnt),
        .at_one   (at_one)
    );

    refdiv_ctrl #(
        .CW (CNT_W)
    ) u_ctrl (
        .clk      (osc_clk),
        .rst      (srst),
        .rom_term (term),
        .cnt      (cnt),
        .at_one   (at_one),
        .cnt_load (cnt_load),
        .cnt_dec  (cnt_dec),
        .tick     (ref_tick)
    );

    // R6: a reset edge leaves the output low and the count cleared
    assert_reset_clear_R6: assert property (@(posedge osc_clk)
        srst |=> (!ref_tick && cnt == '0));

    // R3: never two pulses in a row
    assert_no_double_R3: assert property (@(posedge osc_clk) disable iff (srst)
        ref_tick |=> !ref_tick);

endmodule

// File: tb/tb_ref_code_divider.sv
module tb_ref_code_divider;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int RATIO [8]  = '{8, 64, 128, 256, 640, 1000, 1024, 2048};

    typedef struct {
        int    cyc;
        int    code;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] code_r = 3'd0;
    logic       ref_tick;

    int   cyc = 0;
    int   base = 0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    exp_t q [$];

    ref_code_divider dut (
        .osc_clk    (clk),
        .srst       (rst),
        .ratio_code (code_r),
        .ref_tick   (ref_tick)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Edges since reset release; edge 1 is the loading edge.
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst = 1'b1;
        q.delete();
        repeat (n) @(negedge clk);
        rst  = 1'b0;
        base = 0;
    endtask

    // Drive one period: choose the code before its loading edge, queue the
    // expected pulse, and optionally change the code partway through.
    task automatic run_period(input int code, input string tag,
                              input int chg = 0, input int newcode = 0);
        exp_t e;
        while (cyc != base) @(negedge clk);
        code_r = 3'(code);
        e.cyc  = base + RATIO[code];
        e.code = code;
        e.tag  = tag;
        q.push_back(e);
        if (chg > 0) begin
            while (cyc != base + chg) @(negedge clk);
            code_r = 3'(newcode);
        end
        base += RATIO[code];
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD / 4);
            if (rst) begin
                checks++;
                if (ref_tick !== 1'b0) begin
                    errors++;
                    $display("FAIL R6: reset cycle ref_tick=%0b expected 0", ref_tick);
                end
            end else if (q.size() > 0 && q[0].cyc == cyc) begin
                checks++;
                if (ref_tick !== 1'b1) begin
                    errors++;
                    $display("FAIL %s: code %0d cycle %0d ref_tick=%0b expected 1",
                             q[0].tag, q[0].code, cyc, ref_tick);
                end
                void'(q.pop_front());
            end else if (ref_tick !== 1'b0) begin
                checks++;
                errors++;
                $display("FAIL R2/R3: unexpected pulse at cycle %0d ref_tick=%0b expected 0",
                         cyc, ref_tick);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, pending=%0d expected 0", q.size());
        report();
    end

    // Driver
    initial begin
        do_reset(3);
        // R1 / R2: every code, two periods each, ascending
        for (int c = 0; c < 8; c++) begin
            run_period(c, "R1");
            run_period(c, "R2");
        end
        // R5: code changes strictly inside a period
        run_period(0, "R5", 3, 7);
        run_period(7, "R5");
        run_period(5, "R5", 500, 1);
        run_period(1, "R5");
        // R3: smallest ratio back to back
        for (int k = 0; k < 4; k++) run_period(0, "R3");
        // R6: reset in the middle of a 640 count discards it
        run_period(4, "R6");
        repeat (100) @(negedge clk);
        do_reset(2);
        // R4: first pulse after release at edge D
        run_period(2, "R4");
        run_period(6, "R4");
        while (q.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
        report();
    end

endmodule